// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block models a small pipelined synchronous SRAM, 18 bits wide and 64 words deep by default. It takes one command on each enabled rising clock edge, either a read or a write, in any mix and with no idle cycles when the bus changes direction. Every input is registered. Read data leaves through an output register. Write data trails its address by two enabled edges, and a two-stage write address chain carries the address and byte selects while the data is in flight. A read that needs a word whose write data is on the bus at that same edge is served through a forwarding path, so it never returns stale data.

A load cycle (`adv_i` low) takes a new address, a new command and a new chip selection. An advance cycle (`adv_i` high) steps a 2-bit burst counter from the last loaded address and repeats the last command type. The step follows either a linear or an interleaved order. The bidirectional data bus is split into `dq_i`, `dq_o` and a drive enable `dq_oe_o`. That drive enable is gated at once by an active-low output enable.

Top module: `pipe_sram`

## Requirements
- R1: While `rst_ni` is low and after it rises, the pipeline holds no command, and `dq_oe_o` stays low until a read reaches its data cycle.
- R2: A read loaded at enabled edge k loads the stored word into `dq_o` at the next enabled edge (k+1). `dq_oe_o` is high from then until the following enabled edge, provided `oe_ni` is low.
- R3: A load cycle selects the device only when `ce_a_ni`=0, `ce_b_i`=1 and `ce_c_ni`=0 together. Otherwise the cycle is a deselect: no word is written and the bus is not driven in its data cycle.
- R4: While `clk_en_i` is low, no register or memory word changes. This includes `dq_o` and the pending write. The cycle in progress is stretched.
- R5: A write loaded at enabled edge k samples `dq_i` at enabled edge k+2. `byte_wr_i[0]` gates bits 8:0 and `byte_wr_i[1]` gates bits 17:9. A lane that is not selected keeps its old value.
- R6: `oe_ni` high forces `dq_oe_o` low with no clock involved. It has no effect on stored data or on the pipeline.
- R7: For a write loaded at edge k, `dq_oe_o` is low between edges k+1 and k+2, the cycle in which its data is on the bus.
- R8: On an advance cycle the address bits above bit 1 come from the last load. Bits 1:0 are base+n modulo 4 when `burst_ilv_i`=0 and base XOR n when `burst_ilv_i`=1, where n is the advance count modulo 4. Command type and selection repeat from the load. `wr_en_i` and the chip enables are ignored, while `byte_wr_i` is sampled afresh.
- R9: Reads and writes alternate on consecutive enabled edges with no wait state and with correct data.
- R10: A read loaded one enabled edge after a write to the same address returns the written lanes merged over the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Clock enable; low stalls every register |
| addr_i | input | AW | Word address, taken on load cycles |
| adv_i | input | 1 | 1: advance burst, 0: load new command |
| wr_en_i | input | 1 | 1: write, 0: read (load cycles) |
| byte_wr_i | input | 2 | Per-lane write select, bit l covers bits 9l+8:9l |
| ce_a_ni | input | 1 | Chip enable, active low |
| ce_b_i | input | 1 | Chip enable, active high |
| ce_c_ni | input | 1 | Chip enable, active low |
| burst_ilv_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| dq_i | input | 18 | Write data from the bus |
| dq_o | output | 18 | Read data to the bus |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
Read data is due one enabled edge after its read is loaded and is compared in the next half cycle. The bus is held for the data that a write loaded at edge k puts on it between edges k+1 and k+2. The bench's reference pipeline moves its stages only on edges where `clk_en_i` is high, so a stall leaves every pending expectation where it was. Write data is taken from whatever the bench drives in the cycle before the commit edge, and that same value feeds the expected result of a forwarded read. Outputs are sampled at the falling edge, before new inputs are applied, so a change of `oe_ni` shows up in the check of the following half cycle.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
  parameter int unsigned LANES  = 2;
  parameter int unsigned LANE_W = 9;
  parameter int unsigned CNT_W  = 2;

  typedef struct packed {
    logic             vld;
    logic             wr;
    logic [LANES-1:0] be;
  } cmd_t;
endpackage

// File: rtl/pipe_sram_burst.sv
module pipe_sram_burst #(
  parameter int unsigned AW    = 6,
  parameter int unsigned CNT_W = pipe_sram_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic             ilv_i,
  input  logic [AW-1:0]    addr_i,
  output logic [AW-1:0]    nxt_addr_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [AW-1:0]    base_q;
  logic [CNT_W-1:0] cnt_q, cnt_n, low_n;

  assign cnt_n = load_i ? '0 : cnt_q + 1'b1;
  assign low_n = ilv_i ? (base_q[CNT_W-1:0] ^ cnt_n) : (base_q[CNT_W-1:0] + cnt_n);

  always_comb begin
    nxt_addr_o = {base_q[AW-1:CNT_W], low_n};
    if (load_i) nxt_addr_o = addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en_i) begin
      if (load_i) base_q <= addr_i;
      cnt_q <= cnt_n;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pipe_sram_array.sv
module pipe_sram_array #(
  parameter int unsigned AW     = 6,
  parameter int unsigned LANES  = pipe_sram_pkg::LANES,
  parameter int unsigned LANE_W = pipe_sram_pkg::LANE_W,
  localparam int unsigned DW    = LANES * LANE_W,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [LANES-1:0] wbe_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o
);
  logic hit;
  assign hit = we_i && (waddr_i == raddr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && wbe_i[l]) mem_q[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    // coherency: lane being written at this edge wins over the array
    assign rdata_o[l*LANE_W +: LANE_W] = (hit && wbe_i[l]) ? wdata_i[l*LANE_W +: LANE_W]
                                                          : mem_q[raddr_i];
  end
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int unsigned AW = 6,
  localparam int unsigned DW = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             adv_i,
  input  logic             wr_en_i,
  input  logic [LANES-1:0] byte_wr_i,
  input  logic             ce_a_ni,
  input  logic             ce_b_i,
  input  logic             ce_c_ni,
  input  logic             burst_ilv_i,
  input  logic             oe_ni,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe_o
);
  logic             sel_now, load;
  logic             op_q, sel_q;
  logic [AW-1:0]    nxt_addr;
  logic [CNT_W-1:0] burst_cnt;
  cmd_t             cmd_n, s1_q, s2_q;
  logic [AW-1:0]    s1_addr, s2_addr;
  logic             s1_vld, s1_wr;
  logic [DW-1:0]    rd_data, dq_q;
  logic             drv_q;

  assign sel_now = !ce_a_ni && ce_b_i && !ce_c_ni;
  assign load    = !adv_i;

  pipe_sram_burst #(.AW(AW), .CNT_W(CNT_W)) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (clk_en_i),
    .load_i     (load),
    .ilv_i      (burst_ilv_i),
    .addr_i     (addr_i),
    .nxt_addr_o (nxt_addr),
    .cnt_o      (burst_cnt)
  );

  always_comb begin
    cmd_n.vld = load ? sel_now : sel_q;
    cmd_n.wr  = load ? wr_en_i : op_q;
    cmd_n.be  = byte_wr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= 1'b0;
      sel_q   <= 1'b0;
      s1_q    <= '0;
      s1_addr <= '0;
      s2_q    <= '0;
      s2_addr <= '0;
      drv_q   <= 1'b0;
      dq_q    <= '0;
    end else if (clk_en_i) begin
      if (load) begin
        op_q  <= wr_en_i;
        sel_q <= sel_now;
      end
      s1_q     <= cmd_n;
      s1_addr  <= nxt_addr;
      s2_q.vld <= s1_q.vld && s1_q.wr;
      s2_q.wr  <= 1'b1;
      s2_q.be  <= s1_q.be;
      s2_addr  <= s1_addr;
      drv_q    <= s1_q.vld && !s1_q.wr;
      if (s1_q.vld && !s1_q.wr) dq_q <= rd_data;
    end
  end

  assign s1_vld = s1_q.vld;
  assign s1_wr  = s1_q.wr;

  pipe_sram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i   (clk_i),
    .we_i    (clk_en_i && s2_q.vld),
    .waddr_i (s2_addr),
    .wbe_i   (s2_q.be),
    .wdata_i (dq_i),
    .raddr_i (s1_addr),
    .rdata_o (rd_data)
  );

  assign dq_o    = dq_q;
  assign dq_oe_o = drv_q && !oe_ni;
endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk #(
  parameter int unsigned AW    = 6,
  parameter int unsigned DW    = 18,
  parameter int unsigned CNT_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clk_en_i,
  input logic             adv_i,
  input logic             ce_a_ni,
  input logic             ce_b_i,
  input logic             ce_c_ni,
  input logic             oe_ni,
  input logic             s1_vld,
  input logic             s1_wr,
  input logic [AW-1:0]    s1_addr,
  input logic [CNT_W-1:0] burst_cnt,
  input logic [DW-1:0]    dq_o,
  input logic             dq_oe_o
);
  a_r4_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> $stable(dq_o) && $stable(s1_vld) && $stable(s1_addr) && $stable(burst_cnt));

  a_r7_write_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_i && s1_vld && s1_wr |=> !dq_oe_o);

  a_r2_read_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_i && s1_vld && !s1_wr |=> dq_oe_o || oe_ni);

  a_r6_oe_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o);

  a_r3_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_i && !adv_i && !(!ce_a_ni && ce_b_i && !ce_c_ni) |=> !s1_vld);

  a_r8_burst_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_i && adv_i |=> burst_cnt == $past(burst_cnt) + 1'b1);
endmodule

bind pipe_sram pipe_sram_chk #(.AW(AW), .DW(DW), .CNT_W(pipe_sram_pkg::CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clk_en_i  (clk_en_i),
  .adv_i     (adv_i),
  .ce_a_ni   (ce_a_ni),
  .ce_b_i    (ce_b_i),
  .ce_c_ni   (ce_c_ni),
  .oe_ni     (oe_ni),
  .s1_vld    (s1_vld),
  .s1_wr     (s1_wr),
  .s1_addr   (s1_addr),
  .burst_cnt (burst_cnt),
  .dq_o      (dq_o),
  .dq_oe_o   (dq_oe_o)
);

// File: tb/pipe_sram_test.sv
module pipe_sram_test;
  localparam int AW = 6;
  localparam int DW = 18;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clk_en_i = 1'b0, adv_i = 1'b0, wr_en_i = 1'b0, burst_ilv_i = 1'b0, oe_ni = 1'b0;
  logic ce_a_ni = 1'b1, ce_b_i = 1'b0, ce_c_ni = 1'b1;
  logic [1:0] byte_wr_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic dq_oe_o;

  always #10 clk = ~clk;

  pipe_sram #(.AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .clk_en_i(clk_en_i), .addr_i(addr_i), .adv_i(adv_i),
    .wr_en_i(wr_en_i), .byte_wr_i(byte_wr_i), .ce_a_ni(ce_a_ni), .ce_b_i(ce_b_i),
    .ce_c_ni(ce_c_ni), .burst_ilv_i(burst_ilv_i), .oe_ni(oe_ni), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  int checks = 0, fails = 0;

  // reference model
  logic [DW-1:0] ref_mem [DEPTH];
  logic          p1_vld = 0, p1_wr = 0, p2_vld = 0;
  logic [1:0]    p1_be = 0, p2_be = 0;
  logic [AW-1:0] p1_addr = 0, p2_addr = 0, b_base = 0;
  logic [1:0]    b_cnt = 0;
  logic          b_op = 0, b_sel = 0;
  logic          exp_drv = 0;
  logic [DW-1:0] exp_dq = 0;
  string         p1_tag = "R1", exp_tag = "R1";

  function automatic logic [1:0] burst_low(logic [1:0] base, logic [1:0] n, logic ilv);
    return ilv ? (base ^ n) : (base + n);
  endfunction

  task automatic check_outputs();
    logic eo;
    string t;
    eo = exp_drv && !oe_ni;
    t  = (exp_drv && oe_ni) ? "R6" : exp_tag;
    checks++;
    if (dq_oe_o !== eo) begin
      fails++;
      $display("FAIL %s dq_oe_o actual=%b expected=%b t=%0t", t, dq_oe_o, eo, $time);
    end
    if (eo) begin
      checks++;
      if (dq_o !== exp_dq) begin
        fails++;
        $display("FAIL %s dq_o actual=%h expected=%h t=%0t", t, dq_o, exp_dq, $time);
      end
    end
  endtask

  // one clock: check, drive, edge, model update; ends at a falling edge
  task automatic tick(input logic en, input logic adv, input logic wr, input logic [1:0] be,
                      input logic [AW-1:0] a, input logic [2:0] ce, input logic ilv,
                      input logic oen, input string tag);
    check_outputs();
    clk_en_i = en; adv_i = adv; wr_en_i = wr; byte_wr_i = be; addr_i = a;
    {ce_a_ni, ce_b_i, ce_c_ni} = ce; burst_ilv_i = ilv; oe_ni = oen;
    dq_i = DW'($urandom);
    @(posedge clk);
    if (en) begin
      if (p2_vld)
        for (int l = 0; l < 2; l++)
          if (p2_be[l]) ref_mem[p2_addr][l*9 +: 9] = dq_i[l*9 +: 9];
      exp_drv = p1_vld && !p1_wr;
      exp_tag = p1_tag;
      if (exp_drv) begin
        exp_dq = ref_mem[p1_addr];
        if (p2_vld && p2_addr == p1_addr) exp_tag = "R10";
      end
      p2_vld = p1_vld && p1_wr; p2_addr = p1_addr; p2_be = p1_be;
      if (!adv) begin
        b_base = a; b_cnt = 0; b_op = wr; b_sel = (ce == 3'b010);
        p1_addr = a;
      end else begin
        b_cnt = b_cnt + 1'b1;
        p1_addr = {b_base[AW-1:2], burst_low(b_base[1:0], b_cnt, ilv)};
      end
      p1_vld = b_sel; p1_wr = b_op; p1_be = be; p1_tag = tag;
    end else begin
      exp_tag = "R4";
    end
    @(negedge clk);
  endtask

  localparam logic [2:0] SEL = 3'b010;
  localparam logic [2:0] NSEL = 3'b110;

  task automatic rd(input logic [AW-1:0] a, input string tag);
    tick(1, 0, 0, 2'b00, a, SEL, 0, 0, tag);
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [1:0] be, input string tag);
    tick(1, 0, 1, be, a, SEL, 0, 0, tag);
  endtask
  task automatic idle(input string tag);
    tick(1, 0, 0, 2'b00, '0, NSEL, 0, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (dq_oe_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 dq_oe_o actual=%b expected=0", dq_oe_o);
    end
    rst_ni = 1'b1;
    @(negedge clk);
    idle("R1"); idle("R1");
    // R5: fill every word
    for (int i = 0; i < DEPTH; i++) wr(AW'(i), 2'b11, "R5");
    idle("R5"); idle("R5");
    for (int i = 0; i < 8; i++) rd(AW'(i), "R2");
    // R5: single lane writes
    wr(6'd5, 2'b01, "R5"); wr(6'd6, 2'b10, "R5"); idle("R5"); idle("R5");
    rd(6'd5, "R5"); rd(6'd6, "R5");
    // R10: read right after write, and after one gap
    wr(6'd9, 2'b10, "R10"); rd(6'd9, "R10");
    wr(6'd10, 2'b11, "R10"); idle("R10"); rd(6'd10, "R10");
    // R9: alternating traffic
    for (int i = 0; i < 16; i++)
      if (i % 2 == 0) wr(AW'(20 + i), 2'b11, "R9"); else rd(AW'(19 + i), "R9");
    idle("R9"); idle("R9");
    // R8: linear write burst from 0x13, chip enables ignored on advance
    tick(1, 0, 1, 2'b11, 6'h13, SEL, 0, 0, "R8");
    tick(1, 1, 0, 2'b11, 6'h00, NSEL, 0, 0, "R8");
    tick(1, 1, 0, 2'b01, 6'h00, 3'b000, 0, 0, "R8");
    tick(1, 1, 0, 2'b11, 6'h00, NSEL, 0, 0, "R8");
    // R8: interleaved read burst of the same block
    tick(1, 0, 0, 2'b00, 6'h13, SEL, 1, 0, "R8");
    for (int i = 0; i < 5; i++) tick(1, 1, 1, 2'b00, 6'h00, NSEL, 1, 0, "R8");
    idle("R8"); idle("R8");
    for (int i = 0; i < 4; i++) rd(AW'(16 + i), "R8");
    // R3: each chip enable at its inactive level blocks a write
    tick(1, 0, 1, 2'b11, 6'd30, 3'b110, 0, 0, "R3");
    tick(1, 0, 1, 2'b11, 6'd31, 3'b000, 0, 0, "R3");
    tick(1, 0, 1, 2'b11, 6'd32, 3'b011, 0, 0, "R3");
    tick(1, 0, 0, 2'b00, 6'd30, 3'b000, 0, 0, "R3");
    idle("R3"); idle("R3");
    rd(6'd30, "R3"); rd(6'd31, "R3"); rd(6'd32, "R3");
    // R4: stalls in the middle of reads and a write
    wr(6'd40, 2'b11, "R4"); rd(6'd41, "R4");
    for (int i = 0; i < 3; i++) tick(0, 0, 1, 2'b11, 6'd41, SEL, 0, 0, "R4");
    rd(6'd40, "R4");
    for (int i = 0; i < 2; i++) tick(0, 1, 0, 2'b11, 6'd40, SEL, 0, 0, "R4");
    idle("R4"); idle("R4");
    // R6: output enable high during a read data cycle, then read again
    rd(6'd41, "R6"); tick(1, 0, 0, 2'b00, 6'd41, NSEL, 0, 1, "R6");
    tick(1, 0, 0, 2'b00, 6'd41, SEL, 0, 0, "R6");
    idle("R6"); idle("R6");
    // R9: random mixed traffic
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] ce;
      ce = ($urandom % 10 == 0) ? 3'($urandom) : SEL;
      tick(($urandom % 10) != 0, ($urandom % 3) == 0, $urandom % 2, 2'($urandom),
           AW'($urandom), ce, $urandom % 2, ($urandom % 10) == 0, "R9");
    end
    idle("R9"); idle("R9");
    check_outputs();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule